// File: doc/BRIEF.md
# Serial Programming Command Slave

This block is the target end of a four-wire programming link. A host drives a serial clock, a data line into the target and an active-high programming reset; the block returns data on a separate output line. The block runs on a faster system clock and oversamples the serial clock. It assembles the incoming bits into fixed four-byte instructions and tracks whether programming access has been unlocked. It hands load, commit and read requests to a separate memory controller.

Every byte the host sends is echoed back one byte slot later. This lets the host confirm that it is aligned to the frame, because the second byte of the unlock instruction comes back while the third byte is being sent. Read instructions issue their request as soon as the address is complete, so that the memory controller's answer is ready for the fourth byte. The memory arrays and the write timing belong to the memory controller and are not part of this block.

Top module: `serprog_cmd_if`

## Requirements
- R1: `mosi` and `sck` each pass through a two-flop synchronizer. `mosi` is sampled on each detected rising edge of `sck` and shifted in MSB first. Eight samples form one byte.
- R2: `miso` changes only in the system clock cycle that follows a detected falling edge of `sck`.
- R3: An instruction is always four bytes, counted by the number of bytes and not by their content. If extra bits shift the host out of alignment, the unlock sequence no longer lands in the first two byte slots, and access stays locked until the next programming reset.
- R4: Apart from a read reply, each byte slot returns on `miso`, MSB first, the byte that was received just before it. In particular, the 0x53 of the unlock instruction comes back during the third byte.
- R5: A frame that starts with 0xAC 0x53 sets `prog_mode` when its fourth byte completes. `prog_mode` stays set until `prog_rst` or `rst_n` clears it. A later frame with any other second byte does not change it.
- R6: While `prog_mode` is low, no request is issued for any opcode, reads included.
- R7: Load and commit opcodes map to `req_kind` codes as follows: 0x40 gives 1, 0x48 gives 2, 0x4C gives 3, 0xC1 gives 6, 0xC2 gives 7 and 0xC0 gives 8. After the fourth byte, `req_valid` pulses for one cycle with `req_addr` = {byte 2, byte 3} and `req_data` = byte 4.
- R8: Read opcodes map as follows: 0x20 gives 4, 0x28 gives 5 and 0xA0 gives 9. The request pulses after the third byte with `req_addr` = {byte 2, byte 3}. `rd_data` is taken in the cycle after `req_valid` and is returned MSB first during byte four.
- R9: `prog_rst` clears the bit counter, the byte counter and `prog_mode`, and any partly received byte is dropped. `rst_n` clears the same state and also sets `miso` and the request outputs to 0.
- R10: Any other opcode in byte one produces no request.
- R11: The link works when every `sck` high phase and low phase lasts 3 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| prog_rst | input | 1 | Active-high programming reset from the host |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| prog_mode | output | 1 | Programming access unlocked |
| req_valid | output | 1 | One-cycle request strobe to the memory controller |
| req_kind | output | 4 | Request code (see R7, R8) |
| req_addr | output | 16 | Request address, {byte 2, byte 3} |
| req_data | output | 8 | Write data (byte 4); 0 for reads |
| rd_data | input | 8 | Read result, valid the cycle after a read request |

## Verification
The hardest case to reach from the ports is a host that has lost bit alignment. Bits are still counted, but the unlock pattern never falls into the first two byte slots. The bench reaches this case by clocking in a few stray bits before a correct unlock frame. It then shows that access stays locked, and that a programming reset in the middle of a byte restores alignment. Read replies at the minimum serial-clock phase of three cycles are also driven, because they leave the least slack between the edge detector, the request and the output shifter.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  typedef enum logic [3:0] {
    K_NONE     = 4'd0,
    K_LD_FL_LO = 4'd1,
    K_LD_FL_HI = 4'd2,
    K_WR_FL_PG = 4'd3,
    K_RD_FL_LO = 4'd4,
    K_RD_FL_HI = 4'd5,
    K_LD_EE_PG = 4'd6,
    K_WR_EE_PG = 4'd7,
    K_WR_EE_BY = 4'd8,
    K_RD_EE    = 4'd9
  } req_kind_e;

  localparam logic [7:0] UNLOCK_B0 = 8'hAC;
  localparam logic [7:0] UNLOCK_B1 = 8'h53;

  // Map byte one of a frame to a request kind
  function automatic req_kind_e decode_op(input logic [7:0] op);
    case (op)
      8'h40:   return K_LD_FL_LO;
      8'h48:   return K_LD_FL_HI;
      8'h4C:   return K_WR_FL_PG;
      8'h20:   return K_RD_FL_LO;
      8'h28:   return K_RD_FL_HI;
      8'hC1:   return K_LD_EE_PG;
      8'hC2:   return K_WR_EE_PG;
      8'hC0:   return K_WR_EE_BY;
      8'hA0:   return K_RD_EE;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic is_read(input req_kind_e k);
    return (k == K_RD_FL_LO) || (k == K_RD_FL_HI) || (k == K_RD_EE);
  endfunction

  function automatic logic is_unlock(input logic [7:0] b0, input logic [7:0] b1);
    return (b0 == UNLOCK_B0) && (b1 == UNLOCK_B1);
  endfunction

endpackage

// File: rtl/serprog_sync_edge.sv
module serprog_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic mosi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] mosi_pipe;
  logic              sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe  <= '0;
      mosi_pipe <= '0;
      sck_q     <= 1'b0;
    end else begin
      sck_pipe  <= {sck_pipe[STAGES-2:0], sck_in};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_in};
      sck_q     <= sck_pipe[STAGES-1];
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_q;
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_q;
  assign mosi_s   = mosi_pipe[STAGES-1];
endmodule

// File: rtl/serprog_frame.sv
module serprog_frame #(
  parameter int BYTE_W      = 8,
  parameter int FRAME_BYTES = 4,
  localparam int BIT_W      = $clog2(BYTE_W),
  localparam int IDX_W      = $clog2(FRAME_BYTES)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  clr,
  input  logic                                  rise,
  input  logic                                  mosi_s,
  output logic [BIT_W-1:0]                      bit_idx,
  output logic [IDX_W-1:0]                      byte_idx,
  output logic                                  byte_done,
  output logic [BYTE_W-1:0]                     byte_val,
  output logic [FRAME_BYTES-2:0][BYTE_W-1:0]    hdr
);
  logic [BYTE_W-2:0] rx_sh;

  assign byte_val  = {rx_sh, mosi_s};
  assign byte_done = rise && (bit_idx == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
    end else if (clr) begin
      bit_idx  <= '0;
      byte_idx <= '0;
      rx_sh    <= '0;
    end else if (rise) begin
      rx_sh   <= byte_val[BYTE_W-2:0];
      bit_idx <= bit_idx + 1'b1;
      if (byte_done)
        byte_idx <= (byte_idx == IDX_W'(FRAME_BYTES - 1)) ? '0 : byte_idx + 1'b1;
    end
  end

  // Header bytes kept for decoding when later bytes complete
  for (genvar i = 0; i < FRAME_BYTES - 1; i++) begin : g_hdr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hdr[i] <= '0;
      else if (!clr && byte_done && byte_idx == IDX_W'(i))
        hdr[i] <= byte_val;
    end
  end
endmodule

// File: rtl/serprog_miso.sv
module serprog_miso #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              at_boundary,
  input  logic              load_echo,
  input  logic [BYTE_W-1:0] echo_val,
  input  logic              load_rd,
  input  logic [BYTE_W-1:0] rd_val,
  output logic              miso
);
  logic [BYTE_W-1:0] pending;
  logic [BYTE_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      tx_sh   <= '0;
    end else begin
      if (load_rd)
        pending <= rd_val;
      else if (load_echo)
        pending <= echo_val;
      if (fall) begin
        if (at_boundary)
          tx_sh <= pending;
        else
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[BYTE_W-1];
endmodule

// File: rtl/serprog_cmd_if.sv
module serprog_cmd_if #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int FRAME_BYTES = 4,
  localparam int ADDR_W     = 2 * BYTE_W,
  localparam int BIT_W      = $clog2(BYTE_W),
  localparam int IDX_W      = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_rst,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              prog_mode,
  output logic              req_valid,
  output logic [3:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BYTE_W-1:0] req_data,
  input  logic [BYTE_W-1:0] rd_data
);
  import serprog_pkg::*;

  localparam logic [IDX_W-1:0] RD_SLOT   = IDX_W'(FRAME_BYTES - 2);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(FRAME_BYTES - 1);

  logic                               sck_rise;
  logic                               sck_fall;
  logic                               mosi_s;
  logic [BIT_W-1:0]                   bit_idx;
  logic [IDX_W-1:0]                   byte_idx;
  logic                               byte_done;
  logic [BYTE_W-1:0]                  byte_val;
  logic [FRAME_BYTES-2:0][BYTE_W-1:0] hdr;
  req_kind_e                          op_kind;
  req_kind_e                          kind_q;
  logic                               rd_issue;
  logic                               wr_issue;
  logic                               unlock_hit;
  logic                               load_rd;

  serprog_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_in   (sck),
    .mosi_in  (mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s)
  );

  serprog_frame #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (prog_rst),
    .rise      (sck_rise),
    .mosi_s    (mosi_s),
    .bit_idx   (bit_idx),
    .byte_idx  (byte_idx),
    .byte_done (byte_done),
    .byte_val  (byte_val),
    .hdr       (hdr)
  );

  assign op_kind    = decode_op(hdr[0]);
  assign unlock_hit = byte_done && (byte_idx == LAST_SLOT) && is_unlock(hdr[0], hdr[1]);
  assign rd_issue   = byte_done && (byte_idx == RD_SLOT) && prog_mode && is_read(op_kind);
  assign wr_issue   = byte_done && (byte_idx == LAST_SLOT) && prog_mode &&
                      (op_kind != K_NONE) && !is_read(op_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_mode <= 1'b0;
      req_valid <= 1'b0;
      kind_q    <= K_NONE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= 1'b0;
      if (prog_rst) begin
        prog_mode <= 1'b0;
      end else begin
        if (unlock_hit)
          prog_mode <= 1'b1;
        if (rd_issue) begin
          req_valid <= 1'b1;
          kind_q    <= op_kind;
          req_addr  <= {hdr[1], byte_val};
          req_data  <= '0;
        end else if (wr_issue) begin
          req_valid <= 1'b1;
          kind_q    <= op_kind;
          req_addr  <= {hdr[1], hdr[2]};
          req_data  <= byte_val;
        end
      end
    end
  end

  assign req_kind = kind_q;
  assign load_rd  = req_valid && is_read(kind_q);

  serprog_miso #(.BYTE_W(BYTE_W)) u_miso (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall        (sck_fall),
    .at_boundary (bit_idx == '0),
    .load_echo   (byte_done),
    .echo_val    (byte_val),
    .load_rd     (load_rd),
    .rd_val      (rd_data),
    .miso        (miso)
  );
endmodule

// File: rtl/serprog_cmd_if_chk.sv
module serprog_cmd_if_chk #(
  parameter int BIT_W = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_rst,
  input logic             sck_rise,
  input logic             sck_fall,
  input logic             miso,
  input logic             prog_mode,
  input logic             req_valid,
  input logic [BIT_W-1:0] bit_idx,
  input logic [IDX_W-1:0] byte_idx
);
  // R2
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(sck_fall));

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R6
  req_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> prog_mode);

  // R1
  req_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(sck_rise));

  // R9
  prog_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_rst |=> (!prog_mode && bit_idx == '0 && byte_idx == '0));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_mode) |-> $past(prog_rst));
endmodule

bind serprog_cmd_if serprog_cmd_if_chk #(.BIT_W(BIT_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog_rst  (prog_rst),
  .sck_rise  (sck_rise),
  .sck_fall  (sck_fall),
  .miso      (miso),
  .prog_mode (prog_mode),
  .req_valid (req_valid),
  .bit_idx   (bit_idx),
  .byte_idx  (byte_idx)
);

// File: tb/serprog_cmd_if_tb.sv
module serprog_cmd_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_rst = 1'b0;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        miso;
  logic        prog_mode;
  logic        req_valid;
  logic [3:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_data;
  logic [7:0]  rd_data;

  int          checks = 0;
  int          errors = 0;
  int          half = 6;
  int          req_cnt = 0;
  logic [3:0]  last_kind = '0;
  logic [15:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic [7:0]  prev_rx = '0;
  logic        mode_exp = 1'b0;

  always #2.5 clk = ~clk;

  serprog_cmd_if u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_rst  (prog_rst),
    .sck       (sck),
    .mosi      (mosi),
    .miso      (miso),
    .prog_mode (prog_mode),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .rd_data   (rd_data)
  );

  // Memory model of the bench
  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign rd_data = mem_val(req_addr);

  always @(negedge clk) begin
    if (req_valid) begin
      req_cnt   <= req_cnt + 1;
      last_kind <= req_kind;
      last_addr <= req_addr;
      last_data <= req_data;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) mosi = tx[i];
      repeat (half) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (half) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic send_frame(input logic [31:0] f, output logic [31:0] r);
    logic [7:0] rb;
    for (int k = 0; k < 4; k++) begin
      xfer_bits(f[31-8*k -: 8], 8, rb);
      r[31-8*k -: 8] = rb;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic prog_reset_pulse();
    @(negedge clk) prog_rst = 1'b1;
    repeat (3) @(negedge clk);
    prog_rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // One frame with full expectation checks
  task automatic run_vec(input logic [31:0] f, input logic exp_req, input logic [3:0] kind);
    logic [31:0] r;
    logic        rd;
    logic [7:0]  e3;
    rd = exp_req && (kind == 4'd4 || kind == 4'd5 || kind == 4'd9);
    e3 = rd ? mem_val(f[23:8]) : f[15:8];
    req_cnt = 0;
    send_frame(f, r);
    check($sformatf("R4 slot0 echo f=%h", f), r[31:24], prev_rx);
    check($sformatf("R4 slot1 echo f=%h", f), r[23:16], f[31:24]);
    check($sformatf("R4 slot2 echo f=%h", f), r[15:8],  f[23:16]);
    check($sformatf("%s slot3 f=%h", rd ? "R8" : "R4", f), r[7:0], e3);
    check($sformatf("R6 R7 R10 request count f=%h", f), req_cnt, exp_req ? 1 : 0);
    if (exp_req) begin
      check($sformatf("R7 kind f=%h", f), last_kind, kind);
      check($sformatf("R8 address f=%h", f), last_addr, f[23:8]);
      if (!rd) check($sformatf("R7 data f=%h", f), last_data, f[7:0]);
    end
    if (f[31:16] == 16'hAC53) mode_exp = 1'b1;
    check($sformatf("R5 prog_mode f=%h", f), prog_mode, mode_exp);
    prev_rx = f[7:0];
  endtask

  // {frame, expect request, expected kind}
  localparam logic [36:0] VEC [14] = '{
    {32'h2001_0200, 1'b0, 4'd0},  // R6 locked read
    {32'h4000_0511, 1'b0, 4'd0},  // R6 locked load
    {32'hAC53_0000, 1'b0, 4'd0},  // R5 unlock, R4 0x53 echo
    {32'h4000_0511, 1'b1, 4'd1},  // R7
    {32'h4800_0522, 1'b1, 4'd2},  // R7
    {32'h4C00_4000, 1'b1, 4'd3},  // R7
    {32'h2001_2300, 1'b1, 4'd4},  // R8
    {32'h280A_BC00, 1'b1, 4'd5},  // R8
    {32'hA000_1F00, 1'b1, 4'd9},  // R8
    {32'hC100_0277, 1'b1, 4'd6},  // R7
    {32'hC200_0400, 1'b1, 4'd7},  // R7
    {32'hC001_1099, 1'b1, 4'd8},  // R7
    {32'h7712_3456, 1'b0, 4'd0},  // R10
    {32'hAC00_0000, 1'b0, 4'd0}   // R5 mode stays set
  };

  initial begin
    logic [31:0] r;
    logic [7:0]  junk;
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 reset miso", miso, 1'b0);
    check("R9 reset prog_mode", prog_mode, 1'b0);
    check("R9 reset req_valid", req_valid, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 14; v++)
      run_vec(VEC[v][36:5], VEC[v][4], VEC[v][3:0]);

    // R11 minimum phase of 3 system clocks
    half = 3;
    run_vec(32'h4000_073C, 1'b1, 4'd1);
    run_vec(32'h2000_0700, 1'b1, 4'd4);
    half = 6;

    // R9 programming reset clears the mode
    prog_reset_pulse();
    mode_exp = 1'b0;
    check("R9 prog_mode after prog_rst", prog_mode, 1'b0);

    // R3 stray bits misalign the frame; unlock is missed
    xfer_bits(8'hFF, 3, junk);
    send_frame(32'hAC53_0000, r);
    check("R3 misaligned unlock ignored", prog_mode, 1'b0);

    // R9 partial byte dropped by prog_rst, alignment restored
    prog_reset_pulse();
    xfer_bits(8'hAC, 5, junk);
    prog_reset_pulse();
    send_frame(32'hAC53_0000, r);
    check("R9 realigned unlock", prog_mode, 1'b1);
    check("R4 unlock echo after realign", r[15:8], 8'h53);
    mode_exp = 1'b1;
    prev_rx = 8'h00;
    run_vec(32'hC000_3344, 1'b1, 4'd8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired (R1 link stalled) actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule